// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block resolves the operand of an accumulator load. An instruction's mode code, address field and register selector arrive with a one-cycle `start` pulse. The block forms the effective address for the selected addressing mode and reads a synchronous memory port zero, one or two times. It then presents the operand and the effective address, and pulses `done`.

A small register file sits inside the block. Its second-highest entry is the index register and its highest entry is the base register. The surrounding pipeline loads it through a write port. The index register steps by one each time an indexed access is accepted. Program-relative accesses add the address field to the address of the following instruction, which is the current instruction address plus the instruction length in words. Address arithmetic wraps modulo 2^AW.

Top module: `operand_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `done`, `mem_re` and `ea_valid` are low and `operand` and `ea` are zero. Reset also clears every register-file entry to zero.
- R2: With `ext_mode`=0 the codes in `mode` are 0 direct, 1 indirect, 2 register direct, 3 register indirect, 4 immediate, 5 relative, 6 indexed and 7 based. In direct mode the block makes one read at `addr_field`, and `ea` equals `addr_field`. `done` is high in the cycle after the third rising edge, counting the edge that samples `start` as the first.
- R3: In indirect mode the block reads `addr_field`, takes the low AW bits of that word as a pointer, and reads the pointer. `ea` is the pointer and `operand` is the second word. `done` follows the fifth edge.
- R4: In register direct mode `operand` is the register picked by `reg_sel`, there is no memory read, `ea_valid` is 0, and `done` follows the first edge. A write on `rf_we`/`rf_wsel`/`rf_wdata` is visible to any start sampled on a later edge.
- R5: In register indirect mode the block makes one read at the low AW bits of the selected register, with `ea` equal to that address and `done` after the third edge.
- R6: In immediate mode `operand` is `addr_field` zero-extended to DW bits. There is no read, `ea_valid` is 0, and `done` follows the first edge.
- R7: With `ext_mode`=1 and `mode[0]`=1 (implicit), `operand` equals `acc_val`. There is no read, `ea_valid` is 0, and `done` follows the first edge.
- R8: With `ext_mode`=1 and `mode[0]`=0 (displacement), `ea` = `addr_field` + the selected register. The block makes one read there and `done` follows the third edge.
- R9: In relative mode `ea` = `cur_pc` + `instr_len` + `addr_field`, modulo 2^AW. The block makes one read there and `done` follows the third edge.
- R10: In indexed mode `ea` = `addr_field` + the index register (entry NREGS-2), with one read. The index register then holds its old value plus one.
- R11: In based mode `ea` = `addr_field` + the base register (entry NREGS-1), with one read and `done` after the third edge.
- R12: A `start` sampled while an access is still in progress is ignored. It causes no extra read and no extra `done`, and it does not change the result.
- R13: `done` is high for exactly one cycle per access, and `mem_re` is high for exactly one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access; sampled only when idle |
| ext_mode | input | 1 | Selects the extended mode group (displacement / implicit) |
| mode | input | 3 | Addressing-mode code |
| addr_field | input | AW | Address, offset or immediate field of the instruction |
| reg_sel | input | RSW | Register selector |
| cur_pc | input | AW | Address of the current instruction |
| instr_len | input | ILW | Length of the current instruction in words |
| acc_val | input | DW | Accumulator value for implicit mode |
| rf_we | input | 1 | Register-file write enable |
| rf_wsel | input | RSW | Register-file write index |
| rf_wdata | input | DW | Register-file write data |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_re` |
| done | output | 1 | Result valid strobe |
| operand | output | DW | Fetched operand |
| ea | output | AW | Effective address |
| ea_valid | output | 1 | High when the mode has an effective address |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of an access, while its read is in flight. Only there does the idle gate matter. The bench holds `start` high across three edges during a direct read and swaps the fields to an immediate load. It then counts reads and `done` pulses over a window and compares the operand with the direct result. The index post-increment cannot be seen on any output of the indexed access itself. So the bench issues two indexed loads in a row and then reads the index register back through register direct mode, expecting the original value plus two.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_INDIRECT = 3'd1,
    AM_REGDIR   = 3'd2,
    AM_REGIND   = 3'd3,
    AM_IMM      = 3'd4,
    AM_REL      = 3'd5,
    AM_INDEXED  = 3'd6,
    AM_BASED    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    FETCH_NONE = 2'd0,
    FETCH_ONE  = 2'd1,
    FETCH_TWO  = 2'd2
  } fetch_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WAIT1 = 3'd1,
    S_PTR   = 3'd2,
    S_WAIT2 = 3'd3,
    S_CAP   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/agen_regfile.sv
module agen_regfile #(
  parameter int DW      = 16,
  parameter int NREGS   = 8,
  parameter int IDX_REG = NREGS - 2,
  parameter int BAS_REG = NREGS - 1,
  localparam int RSW    = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RSW-1:0] wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic           idx_bump,
  input  logic [RSW-1:0] rd_sel,
  output logic [DW-1:0]  rd_data,
  output logic [DW-1:0]  idx_data,
  output logic [DW-1:0]  base_data
);

  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (idx_bump) regs[IDX_REG] <= regs[IDX_REG] + DW'(1);
      if (wr_en)    regs[wr_sel]  <= wr_data;
    end
  end

  assign rd_data   = regs[rd_sel];
  assign idx_data  = regs[IDX_REG];
  assign base_data = regs[BAS_REG];

endmodule

// File: rtl/agen_decode.sv
module agen_decode
  import agen_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int ILW = 2
) (
  input  logic           ext_mode,
  input  logic [2:0]     mode,
  input  logic [AW-1:0]  addr_field,
  input  logic [DW-1:0]  sel_val,
  input  logic [DW-1:0]  idx_val,
  input  logic [DW-1:0]  base_val,
  input  logic [DW-1:0]  acc_val,
  input  logic [AW-1:0]  cur_pc,
  input  logic [ILW-1:0] instr_len,
  output fetch_e         fetch,
  output logic [AW-1:0]  first_addr,
  output logic           ea_ok,
  output logic [DW-1:0]  direct_val
);

  always_comb begin
    fetch      = FETCH_NONE;
    first_addr = '0;
    ea_ok      = 1'b0;
    direct_val = '0;
    if (ext_mode) begin
      if (mode[0]) begin
        direct_val = acc_val;
      end else begin
        fetch      = FETCH_ONE;
        first_addr = addr_field + sel_val[AW-1:0];
        ea_ok      = 1'b1;
      end
    end else begin
      case (amode_e'(mode))
        AM_DIRECT: begin
          fetch      = FETCH_ONE;
          first_addr = addr_field;
          ea_ok      = 1'b1;
        end
        AM_INDIRECT: begin
          fetch      = FETCH_TWO;
          first_addr = addr_field;
          ea_ok      = 1'b1;
        end
        AM_REGDIR: direct_val = sel_val;
        AM_REGIND: begin
          fetch      = FETCH_ONE;
          first_addr = sel_val[AW-1:0];
          ea_ok      = 1'b1;
        end
        AM_IMM: direct_val = DW'(addr_field);
        AM_REL: begin
          fetch      = FETCH_ONE;
          first_addr = cur_pc + AW'(instr_len) + addr_field;
          ea_ok      = 1'b1;
        end
        AM_INDEXED: begin
          fetch      = FETCH_ONE;
          first_addr = addr_field + idx_val[AW-1:0];
          ea_ok      = 1'b1;
        end
        AM_BASED: begin
          fetch      = FETCH_ONE;
          first_addr = addr_field + base_val[AW-1:0];
          ea_ok      = 1'b1;
        end
        default: direct_val = '0;
      endcase
    end
  end

endmodule

// File: rtl/agen_seq.sv
module agen_seq
  import agen_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  fetch_e        fetch,
  input  logic [AW-1:0] first_addr,
  input  logic          ea_ok,
  input  logic [DW-1:0] direct_val,
  input  logic [DW-1:0] mem_rdata,
  output logic          idle,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic [AW-1:0] ea,
  output logic          ea_valid
);

  seq_state_e st;

  assign idle = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mem_re   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      operand  <= '0;
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_re <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            ea_valid <= ea_ok;
            ea       <= ea_ok ? first_addr : '0;
            case (fetch)
              FETCH_NONE: begin
                operand <= direct_val;
                done    <= 1'b1;
              end
              FETCH_ONE: begin
                mem_re   <= 1'b1;
                mem_addr <= first_addr;
                st       <= S_WAIT2;
              end
              default: begin
                mem_re   <= 1'b1;
                mem_addr <= first_addr;
                st       <= S_WAIT1;
              end
            endcase
          end
        end
        S_WAIT1: st <= S_PTR;
        S_PTR: begin
          mem_re   <= 1'b1;
          mem_addr <= mem_rdata[AW-1:0];
          ea       <= mem_rdata[AW-1:0];
          st       <= S_WAIT2;
        end
        S_WAIT2: st <= S_CAP;
        S_CAP: begin
          operand <= mem_rdata;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import agen_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int NREGS   = 8,
  parameter int ILW     = 2,
  parameter int IDX_REG = NREGS - 2,
  parameter int BAS_REG = NREGS - 1,
  localparam int RSW    = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           ext_mode,
  input  logic [2:0]     mode,
  input  logic [AW-1:0]  addr_field,
  input  logic [RSW-1:0] reg_sel,
  input  logic [AW-1:0]  cur_pc,
  input  logic [ILW-1:0] instr_len,
  input  logic [DW-1:0]  acc_val,
  input  logic           rf_we,
  input  logic [RSW-1:0] rf_wsel,
  input  logic [DW-1:0]  rf_wdata,
  output logic           mem_re,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic [DW-1:0]  operand,
  output logic [AW-1:0]  ea,
  output logic           ea_valid
);

  logic          idle;
  logic          go;
  logic          idx_bump;
  logic [DW-1:0] sel_val;
  logic [DW-1:0] idx_val;
  logic [DW-1:0] base_val;
  fetch_e        fetch;
  logic [AW-1:0] first_addr;
  logic          ea_ok;
  logic [DW-1:0] direct_val;

  assign go       = start && idle;
  assign idx_bump = go && !ext_mode && (mode == AM_INDEXED);

  agen_regfile #(
    .DW(DW), .NREGS(NREGS), .IDX_REG(IDX_REG), .BAS_REG(BAS_REG)
  ) u_rf (
    .clk(clk), .rst(rst),
    .wr_en(rf_we), .wr_sel(rf_wsel), .wr_data(rf_wdata),
    .idx_bump(idx_bump), .rd_sel(reg_sel),
    .rd_data(sel_val), .idx_data(idx_val), .base_data(base_val)
  );

  agen_decode #(.AW(AW), .DW(DW), .ILW(ILW)) u_dec (
    .ext_mode(ext_mode), .mode(mode), .addr_field(addr_field),
    .sel_val(sel_val), .idx_val(idx_val), .base_val(base_val),
    .acc_val(acc_val), .cur_pc(cur_pc), .instr_len(instr_len),
    .fetch(fetch), .first_addr(first_addr), .ea_ok(ea_ok),
    .direct_val(direct_val)
  );

  agen_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .go(go), .fetch(fetch),
    .first_addr(first_addr), .ea_ok(ea_ok), .direct_val(direct_val),
    .mem_rdata(mem_rdata), .idle(idle),
    .mem_re(mem_re), .mem_addr(mem_addr), .done(done),
    .operand(operand), .ea(ea), .ea_valid(ea_valid)
  );

endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int NREGS   = 8,
  parameter int IDX_REG = NREGS - 2,
  localparam int RSW    = $clog2(NREGS)
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic           mem_re,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_rdata,
  input logic [DW-1:0]  operand,
  input logic [AW-1:0]  ea,
  input logic           ea_valid,
  input logic [DW-1:0]  idx_val,
  input logic           idx_bump,
  input logic           rf_we,
  input logic [RSW-1:0] rf_wsel
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!done && !mem_re && !ea_valid));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  // R2
  last_read_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(mem_re, 2)) |-> (ea == $past(mem_addr, 2)));

  // R3
  read_data_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(mem_re, 2)) |-> (operand == $past(mem_rdata)));

  // R10
  index_step_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_bump && !(rf_we && rf_wsel == RSW'(IDX_REG)))
      |=> (idx_val == $past(idx_val) + DW'(1)));

endmodule

bind operand_addr_gen agen_checker #(
  .DW(DW), .AW(AW), .NREGS(NREGS), .IDX_REG(IDX_REG)
) i_chk (.*);

// File: tb/test_operand_addr_gen.sv
module test_operand_addr_gen;

  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NREGS = 8;
  localparam int ILW = 2;
  localparam int RSW = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           ext_mode = 1'b0;
  logic [2:0]     mode = '0;
  logic [AW-1:0]  addr_field = '0;
  logic [RSW-1:0] reg_sel = '0;
  logic [AW-1:0]  cur_pc = '0;
  logic [ILW-1:0] instr_len = '0;
  logic [DW-1:0]  acc_val = 16'hBEEF;
  logic           rf_we = 1'b0;
  logic [RSW-1:0] rf_wsel = '0;
  logic [DW-1:0]  rf_wdata = '0;
  logic           mem_re;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_rdata = '0;
  logic           done;
  logic [DW-1:0]  operand;
  logic [AW-1:0]  ea;
  logic           ea_valid;

  int n_cmp = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  logic [DW-1:0] tb_rf [NREGS];

  always #4 clk = ~clk;

  operand_addr_gen #(.DW(DW), .AW(AW), .NREGS(NREGS), .ILW(ILW)) i_operand_addr_gen (
    .clk(clk), .rst(rst), .start(start), .ext_mode(ext_mode), .mode(mode),
    .addr_field(addr_field), .reg_sel(reg_sel), .cur_pc(cur_pc),
    .instr_len(instr_len), .acc_val(acc_val), .rf_we(rf_we),
    .rf_wsel(rf_wsel), .rf_wdata(rf_wdata), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
    .operand(operand), .ea(ea), .ea_valid(ea_valid)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return DW'(a) * 16'h0131 + 16'h0057;
  endfunction

  function automatic logic [DW-1:0] reg_init(input int i);
    return DW'(i) * 16'h0123 + 16'h0010;
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= mem_word(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic ext, input logic [2:0] m);
    if (ext) return m[0] ? "R7" : "R8";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  typedef struct packed {
    logic       ext;
    logic [2:0] mode;
    logic [7:0] addr;
    logic [2:0] rsel;
    logic [7:0] pc;
    logic [1:0] ilen;
    logic [1:0] reads;
    logic [2:0] lat;
    logic       eav;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 8'h10, 3'd0, 8'h00, 2'd0, 2'd1, 3'd3, 1'b1},
    '{1'b0, 3'd1, 8'h22, 3'd0, 8'h00, 2'd0, 2'd2, 3'd5, 1'b1},
    '{1'b0, 3'd2, 8'h00, 3'd3, 8'h00, 2'd0, 2'd0, 3'd1, 1'b0},
    '{1'b0, 3'd3, 8'h00, 3'd5, 8'h00, 2'd0, 2'd1, 3'd3, 1'b1},
    '{1'b0, 3'd4, 8'hC7, 3'd0, 8'h00, 2'd0, 2'd0, 3'd1, 1'b0},
    '{1'b0, 3'd5, 8'h05, 3'd0, 8'h0A, 2'd2, 2'd1, 3'd3, 1'b1},
    '{1'b0, 3'd6, 8'h05, 3'd0, 8'h00, 2'd0, 2'd1, 3'd3, 1'b1},
    '{1'b0, 3'd6, 8'h05, 3'd0, 8'h00, 2'd0, 2'd1, 3'd3, 1'b1},
    '{1'b0, 3'd2, 8'h00, 3'd6, 8'h00, 2'd0, 2'd0, 3'd1, 1'b0},
    '{1'b0, 3'd7, 8'h30, 3'd0, 8'h00, 2'd0, 2'd1, 3'd3, 1'b1},
    '{1'b1, 3'd0, 8'h40, 3'd2, 8'h00, 2'd0, 2'd1, 3'd3, 1'b1},
    '{1'b1, 3'd1, 8'h00, 3'd0, 8'h00, 2'd0, 2'd0, 3'd1, 1'b0},
    '{1'b0, 3'd5, 8'h04, 3'd0, 8'hFE, 2'd3, 2'd1, 3'd3, 1'b1},
    '{1'b0, 3'd0, 8'hFF, 3'd0, 8'h00, 2'd0, 2'd1, 3'd3, 1'b1},
    '{1'b0, 3'd1, 8'h00, 3'd0, 8'h00, 2'd0, 2'd2, 3'd5, 1'b1}
  };

  // Independent model of the requirements; tracks the index register.
  task automatic model(input vec_t v, output logic [DW-1:0] eo, output logic [AW-1:0] ee);
    logic [AW-1:0] p;
    eo = '0;
    ee = '0;
    if (v.ext) begin
      if (v.mode[0]) eo = acc_val;
      else begin ee = v.addr + tb_rf[v.rsel][AW-1:0]; eo = mem_word(ee); end
    end else begin
      case (v.mode)
        3'd0: begin ee = v.addr; eo = mem_word(ee); end
        3'd1: begin p = mem_word(v.addr)[AW-1:0]; ee = p; eo = mem_word(p); end
        3'd2: eo = tb_rf[v.rsel];
        3'd3: begin ee = tb_rf[v.rsel][AW-1:0]; eo = mem_word(ee); end
        3'd4: eo = DW'(v.addr);
        3'd5: begin ee = v.pc + AW'(v.ilen) + v.addr; eo = mem_word(ee); end
        3'd6: begin
          ee = v.addr + tb_rf[NREGS-2][AW-1:0];
          eo = mem_word(ee);
          tb_rf[NREGS-2] = tb_rf[NREGS-2] + 1'b1;
        end
        default: begin ee = v.addr + tb_rf[NREGS-1][AW-1:0]; eo = mem_word(ee); end
      endcase
    end
  endtask

  task automatic run_op(input vec_t v, output int lat, output int reads);
    int r0;
    @(negedge clk);
    start = 1'b1; ext_mode = v.ext; mode = v.mode; addr_field = v.addr;
    reg_sel = v.rsel; cur_pc = v.pc; instr_len = v.ilen;
    r0 = rd_cnt;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      if (done) begin lat = k; break; end
      @(negedge clk);
    end
    reads = rd_cnt - r0;
  endtask

  task automatic write_reg(input int i, input logic [DW-1:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_wsel = RSW'(i); rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    tb_rf[i] = d;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    int lat, reads, d0, r0;
    logic [DW-1:0] eo;
    logic [AW-1:0] ee;

    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "done", done, 0);
    chk("R1", "mem_re", mem_re, 0);
    chk("R1", "operand", operand, 0);
    chk("R1", "ea", ea, 0);
    chk("R1", "ea_valid", ea_valid, 0);
    rst = 1'b0;
    for (int i = 0; i < NREGS; i++) tb_rf[i] = '0;

    // R1: register file cleared by reset
    v = '{1'b0, 3'd2, 8'h00, 3'd6, 8'h00, 2'd0, 2'd0, 3'd1, 1'b0};
    run_op(v, lat, reads);
    chk("R1", "index reg after reset", operand, 0);

    for (int i = 0; i < NREGS; i++) write_reg(i, reg_init(i));

    for (int n = 0; n < NV; n++) begin
      string rq;
      v = VECS[n];
      rq = req_of(v.ext, v.mode);
      model(v, eo, ee);
      run_op(v, lat, reads);
      chk(rq, "operand", operand, eo);
      chk(rq, "ea_valid", ea_valid, v.eav);
      if (v.eav) chk(rq, "ea", ea, ee);
      chk(rq, "reads", reads, v.reads);
      chk(rq, "latency", lat, v.lat);
      @(negedge clk);
      // R13: done lasts one cycle
      chk("R13", "done width", done, 0);
    end

    // R9: worked example, next-instruction address 12 plus 5 is 17
    v = '{1'b0, 3'd5, 8'h05, 3'd0, 8'h0A, 2'd2, 2'd1, 3'd3, 1'b1};
    run_op(v, lat, reads);
    chk("R9", "relative ea", ea, 8'd17);

    // R12: start held during a direct read, fields switched to immediate
    @(negedge clk);
    d0 = done_cnt; r0 = rd_cnt;
    start = 1'b1; ext_mode = 1'b0; mode = 3'd0; addr_field = 8'h33;
    @(negedge clk);
    mode = 3'd4; addr_field = 8'h99;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12", "done pulses", done_cnt - d0, 1);
    chk("R12", "reads", rd_cnt - r0, 1);
    chk("R12", "operand", operand, mem_word(8'h33));

    // R1: reset in the middle of an indirect access
    @(negedge clk);
    start = 1'b1; ext_mode = 1'b0; mode = 3'd1; addr_field = 8'h22;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    d0 = done_cnt;
    chk("R1", "mem_re after reset", mem_re, 0);
    chk("R1", "ea after reset", ea, 0);
    repeat (6) @(negedge clk);
    chk("R1", "no done after reset", done_cnt - d0, 0);
    v = '{1'b0, 3'd2, 8'h00, 3'd3, 8'h00, 2'd0, 2'd0, 3'd1, 1'b0};
    run_op(v, lat, reads);
    chk("R1", "register cleared", operand, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule